// File: doc/BRIEF.md
# Raster Timing Generator with Table-Driven Line Types

This block produces the horizontal and vertical timing of a video raster from a single pixel clock. A pixel counter walks across each line and a line counter walks down the whole frame, running through the first field and straight on into the second field without restarting. For every line, a small programmed table of line-number breakpoints chooses one of four predefined line shapes. Within the chosen shape, each pixel position falls into an excursion such as sync tip, tri-level pulse, porch, broad pulse or half-line sync. Each excursion carries its own programmed duration and amplitude. The result is a per-sample override level and an enable that a downstream DAC data path uses to replace its normal picture samples.

The generator stays idle, with both counts at zero and the override off, until it sees a vertical sync that marks field 1. Each later rising edge of vertical sync samples the field ID and realigns the counters on the next rising edge of horizontal sync. All configuration inputs are copied into shadow registers only at a frame boundary, so software may rewrite them at any time without tearing the current frame.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel count runs 0, 1, … up to total-pixels − 1, then returns to 0, and the line count advances by one at that wrap.
- R2: The line count runs from 0 to frame-lines − 1 across both fields, then wraps to 0. The field output is 0 while the line count is below field-lines and 1 from there to the end of the frame.
- R3: A rising edge of `vs_in` samples `fid_in` at that clock. The counters realign on the first rising edge of `hs_in` in the same clock or later. A sampled 0 loads pixel 0, line 0, field 0, and a sampled 1 loads pixel 0, line field-lines, field 1. A change of `fid_in` after the vertical edge has no effect on that realignment.
- R4: Until the first realignment with a sampled field ID of 0, `pix_cnt` and `line_cnt` stay 0 and `ovr_en` stays 0. A realignment with a sampled field ID of 1 during this time is ignored.
- R5: When field-lines equals frame-lines (progressive), the field output stays 0, and a vertical sync with field ID 1 does not move the counters.
- R6: The line type is the type of the last table entry (entries 0 to 7) whose breakpoint is at or below the current line. If no entry qualifies, the type is 1. The codes are 0 = active, 1 = blank, 2 = broad, 3 = half-line sync.
- R7: Type 0 and type 1 lines follow the same segments: sync level for the sync duration, then tri-level for the tri duration, then blank for the back-porch duration. The last front-porch pixels of the line are also blank. Between the porches, a type 0 line clears `ovr_en`, while a type 1 line drives blank.
- R8: A type 2 line outputs the sync level for the broad duration from pixel 0, and blank after that.
- R9: A type 3 line outputs the sync level for the sync duration from pixel 0, again for the sync duration from pixel total/2 (rounded down), and blank elsewhere.
- R10: Configuration changes take effect from the first sample of the next frame. That sample is line 0, pixel 0, reached either by a wrap or by a field-1 realignment.
- R11: Whenever `ovr_en` is 0, `ovr_level` is 0.
- R12: All outputs are registered and describe the same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Horizontal sync input, rising edge active |
| vs_in | input | 1 | Vertical sync input, rising edge active |
| fid_in | input | 1 | Field ID, 0 = field 1 |
| cfg_total_pix | input | PIX_W | Pixels per line |
| cfg_field_lines | input | LINE_W | Lines in field 1 |
| cfg_frame_lines | input | LINE_W | Lines in the whole frame |
| cfg_bp_line | input | NUM_BP*LINE_W | Breakpoint line of each table entry, entry i at bits i*LINE_W |
| cfg_bp_kind | input | NUM_BP*2 | Line type code of each table entry, entry i at bits 2*i |
| cfg_dur_sync | input | PIX_W | Sync tip duration |
| cfg_dur_tri | input | PIX_W | Tri-level pulse duration |
| cfg_dur_back | input | PIX_W | Back porch duration |
| cfg_dur_front | input | PIX_W | Front porch duration |
| cfg_dur_broad | input | PIX_W | Broad pulse duration |
| cfg_lvl_sync | input | LVL_W | Sync tip amplitude |
| cfg_lvl_tri | input | LVL_W | Tri-level pulse amplitude |
| cfg_lvl_blank | input | LVL_W | Blank amplitude |
| pix_cnt | output | PIX_W | Pixel count of the current sample |
| line_cnt | output | LINE_W | Line count of the current sample |
| field | output | 1 | Current field, 0 = field 1 |
| line_type | output | 2 | Selected line type code |
| ovr_level | output | LVL_W | Override amplitude |
| ovr_en | output | 1 | Override enable for the DAC path |

## Verification
The bench starts the generator and then lets it run free through whole interlaced frames. Every sample is compared with a model of the counters and of all four line shapes, which separates errors in wrap points, field boundaries, table lookup and segment edges.

A vertical edge that arrives ahead of its horizontal edge, with the field ID changed in between, shows whether the field ID is sampled at the vertical edge or at the horizontal one. Vertical syncs with field ID 1, sent first while idle and later in a progressive setup, show whether they are correctly ignored. Rewriting the line length, levels and table in the middle of a frame shows whether the new values are held back to the frame boundary. A table whose first breakpoint lies above line 0 exercises the fallback type.

// File: rtl/rtg_pkg.sv
`timescale 1ns/1ps
package rtg_pkg;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    LT_ACTIVE = 2'd0,
    LT_BLANK  = 2'd1,
    LT_BROAD  = 2'd2,
    LT_HALF   = 2'd3
  } line_kind_e;
endpackage

// File: rtl/rtg_sync_in.sv
`timescale 1ns/1ps
module rtg_sync_in (
  input  logic clk,
  input  logic rst,
  input  logic hs_in,
  input  logic vs_in,
  input  logic fid_in,
  input  logic split_ok,
  output logic load_f1,
  output logic load_f2,
  output logic running
);
  logic hs_q, vs_q, pend_q, fid_q, run_q;
  logic hs_rise, vs_rise, load, load_fid;

  assign hs_rise  = hs_in & ~hs_q;
  assign vs_rise  = vs_in & ~vs_q;
  assign load     = hs_rise & (vs_rise | pend_q);
  assign load_fid = vs_rise ? fid_in : fid_q;
  assign load_f1  = load & ~load_fid;
  assign load_f2  = load & load_fid & run_q & split_ok;
  assign running  = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      pend_q <= 1'b0;
      fid_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      hs_q <= hs_in;
      vs_q <= vs_in;
      if (vs_rise) begin
        fid_q  <= fid_in;
        pend_q <= ~hs_rise;
      end else if (hs_rise) begin
        pend_q <= 1'b0;
      end
      if (load_f1) run_q <= 1'b1;
    end
  end

  // R4: the generator only begins running on a field-1 realignment
  assert_start_needs_f1_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(load_f1));

  // R3: a pending vertical edge is consumed by the horizontal edge
  assert_pend_consumed_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && hs_rise && !vs_rise) |=> !pend_q);
endmodule

// File: rtl/rtg_shadow.sv
`timescale 1ns/1ps
module rtg_shadow #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11,
  parameter int LVL_W  = 10,
  parameter int NUM_BP = 8,
  localparam int TBL_LW = NUM_BP * LINE_W,
  localparam int TBL_KW = NUM_BP * 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [PIX_W-1:0]  in_tot,
  input  logic [LINE_W-1:0] in_field,
  input  logic [LINE_W-1:0] in_frame,
  input  logic [TBL_LW-1:0] in_bp_line,
  input  logic [TBL_KW-1:0] in_bp_kind,
  input  logic [PIX_W-1:0]  in_sync,
  input  logic [PIX_W-1:0]  in_tri,
  input  logic [PIX_W-1:0]  in_back,
  input  logic [PIX_W-1:0]  in_front,
  input  logic [PIX_W-1:0]  in_broad,
  input  logic [LVL_W-1:0]  in_lvl_sync,
  input  logic [LVL_W-1:0]  in_lvl_tri,
  input  logic [LVL_W-1:0]  in_lvl_blank,
  output logic [PIX_W-1:0]  s_tot,
  output logic [LINE_W-1:0] s_field,
  output logic [LINE_W-1:0] s_frame,
  output logic [TBL_LW-1:0] s_bp_line,
  output logic [TBL_KW-1:0] s_bp_kind,
  output logic [PIX_W-1:0]  s_sync,
  output logic [PIX_W-1:0]  s_tri,
  output logic [PIX_W-1:0]  s_back,
  output logic [PIX_W-1:0]  s_front,
  output logic [PIX_W-1:0]  s_broad,
  output logic [LVL_W-1:0]  s_lvl_sync,
  output logic [LVL_W-1:0]  s_lvl_tri,
  output logic [LVL_W-1:0]  s_lvl_blank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s_tot       <= '0;
      s_field     <= '0;
      s_frame     <= '0;
      s_bp_line   <= '0;
      s_bp_kind   <= '0;
      s_sync      <= '0;
      s_tri       <= '0;
      s_back      <= '0;
      s_front     <= '0;
      s_broad     <= '0;
      s_lvl_sync  <= '0;
      s_lvl_tri   <= '0;
      s_lvl_blank <= '0;
    end else if (upd) begin
      s_tot       <= in_tot;
      s_field     <= in_field;
      s_frame     <= in_frame;
      s_bp_line   <= in_bp_line;
      s_bp_kind   <= in_bp_kind;
      s_sync      <= in_sync;
      s_tri       <= in_tri;
      s_back      <= in_back;
      s_front     <= in_front;
      s_broad     <= in_broad;
      s_lvl_sync  <= in_lvl_sync;
      s_lvl_tri   <= in_lvl_tri;
      s_lvl_blank <= in_lvl_blank;
    end
  end
endmodule

// File: rtl/rtg_counters.sv
`timescale 1ns/1ps
module rtg_counters #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              running,
  input  logic              load_f1,
  input  logic              load_f2,
  input  logic [PIX_W-1:0]  tot,
  input  logic [LINE_W-1:0] field_sz,
  input  logic [LINE_W-1:0] frame_sz,
  output logic [PIX_W-1:0]  pix_q,
  output logic [LINE_W-1:0] line_q,
  output logic              field_q,
  output logic              frame_upd
);
  logic eol, eof;
  logic [LINE_W-1:0] line_nx;

  assign eol       = (pix_q >= tot - PIX_W'(1));
  assign eof       = (line_q >= frame_sz - LINE_W'(1));
  assign line_nx   = line_q + LINE_W'(1);
  assign frame_upd = ~running | load_f1 | (running & ~load_f2 & eol & eof);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (load_f1) begin
      pix_q   <= '0;
      line_q  <= '0;
      field_q <= 1'b0;
    end else if (load_f2) begin
      pix_q   <= '0;
      line_q  <= field_sz;
      field_q <= 1'b1;
    end else if (running) begin
      if (eol) begin
        pix_q <= '0;
        if (eof) begin
          line_q  <= '0;
          field_q <= 1'b0;
        end else begin
          line_q <= line_nx;
          if (line_nx == field_sz) field_q <= 1'b1;
        end
      end else begin
        pix_q <= pix_q + PIX_W'(1);
      end
    end
  end

  assert_pix_range_R1: assert property (@(posedge clk) disable iff (rst)
    running |-> (pix_q < tot));

  assert_pix_step_R1: assert property (@(posedge clk) disable iff (rst)
    (running && !load_f1 && !load_f2 && !eol) |=> (pix_q == $past(pix_q) + PIX_W'(1)));

  assert_line_range_R2: assert property (@(posedge clk) disable iff (rst)
    running |-> (line_q < frame_sz));

  assert_field_matches_line_R2: assert property (@(posedge clk) disable iff (rst)
    running |-> (field_q == (line_q >= field_sz)));
endmodule

// File: rtl/rtg_line_sel.sv
`timescale 1ns/1ps
module rtg_line_sel
  import rtg_pkg::*;
#(
  parameter int LINE_W = 11,
  parameter int NUM_BP = 8,
  localparam int TBL_LW = NUM_BP * LINE_W,
  localparam int TBL_KW = NUM_BP * KIND_W
) (
  input  logic [LINE_W-1:0] line,
  input  logic [TBL_LW-1:0] bp_line,
  input  logic [TBL_KW-1:0] bp_kind,
  output line_kind_e        kind
);
  logic [NUM_BP-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BP; gi++) begin : g_cmp
      assign hit[gi] = (bp_line[gi*LINE_W +: LINE_W] <= line);
    end
  endgenerate

  always_comb begin
    kind = LT_BLANK;
    for (int i = 0; i < NUM_BP; i++) begin
      if (hit[i]) kind = line_kind_e'(bp_kind[i*KIND_W +: KIND_W]);
    end
  end
endmodule

// File: rtl/rtg_shaper.sv
`timescale 1ns/1ps
module rtg_shaper
  import rtg_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11,
  parameter int LVL_W  = 10,
  localparam int SW = PIX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic              fld,
  input  line_kind_e        kind,
  input  logic [PIX_W-1:0]  tot,
  input  logic [PIX_W-1:0]  d_sync,
  input  logic [PIX_W-1:0]  d_tri,
  input  logic [PIX_W-1:0]  d_back,
  input  logic [PIX_W-1:0]  d_front,
  input  logic [PIX_W-1:0]  d_broad,
  input  logic [LVL_W-1:0]  l_sync,
  input  logic [LVL_W-1:0]  l_tri,
  input  logic [LVL_W-1:0]  l_blank,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o,
  output logic              field_o,
  output logic [KIND_W-1:0] kind_o,
  output logic [LVL_W-1:0]  lvl_o,
  output logic              en_o
);
  logic [SW-1:0] p, e_sync, e_tri, e_back, fp_start, half, half_end, e_broad;
  logic              seg_en;
  logic [LVL_W-1:0]  seg_lvl;

  assign p        = SW'(pix);
  assign e_sync   = SW'(d_sync);
  assign e_tri    = e_sync + SW'(d_tri);
  assign e_back   = e_tri + SW'(d_back);
  assign fp_start = SW'(tot) - SW'(d_front);
  assign half     = SW'(tot >> 1);
  assign half_end = half + e_sync;
  assign e_broad  = SW'(d_broad);

  always_comb begin
    seg_en  = 1'b1;
    seg_lvl = l_blank;
    unique case (kind)
      LT_ACTIVE, LT_BLANK: begin
        if (p < e_sync)          seg_lvl = l_sync;
        else if (p < e_tri)      seg_lvl = l_tri;
        else if (p < e_back)     seg_lvl = l_blank;
        else if (p >= fp_start)  seg_lvl = l_blank;
        else if (kind == LT_ACTIVE) begin
          seg_en  = 1'b0;
          seg_lvl = '0;
        end
      end
      LT_BROAD: begin
        if (p < e_broad) seg_lvl = l_sync;
      end
      default: begin
        if ((p < e_sync) || ((p >= half) && (p < half_end))) seg_lvl = l_sync;
      end
    endcase
    if (!valid) begin
      seg_en  = 1'b0;
      seg_lvl = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_o   <= '0;
      line_o  <= '0;
      field_o <= 1'b0;
      kind_o  <= LT_BLANK;
      lvl_o   <= '0;
      en_o    <= 1'b0;
    end else begin
      pix_o   <= valid ? pix  : '0;
      line_o  <= valid ? line : '0;
      field_o <= valid & fld;
      kind_o  <= kind;
      lvl_o   <= seg_lvl;
      en_o    <= seg_en;
    end
  end

  // R4: nothing is overridden while the generator is idle
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!en_o && pix_o == '0 && line_o == '0));

  // R8: a broad line opens with the sync amplitude
  assert_broad_opens_sync_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && kind == LT_BROAD && pix == '0 && d_broad != '0) |=> (en_o && lvl_o == $past(l_sync)));

  // R12: the registered counts follow the counter stage one cycle later
  assert_count_stage_R12: assert property (@(posedge clk) disable iff (rst)
    valid |=> (pix_o == $past(pix) && line_o == $past(line)));
endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11,
  parameter int LVL_W  = 10,
  parameter int NUM_BP = 8,
  localparam int TBL_LW = NUM_BP * LINE_W,
  localparam int TBL_KW = NUM_BP * KIND_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              fid_in,
  input  logic [PIX_W-1:0]  cfg_total_pix,
  input  logic [LINE_W-1:0] cfg_field_lines,
  input  logic [LINE_W-1:0] cfg_frame_lines,
  input  logic [TBL_LW-1:0] cfg_bp_line,
  input  logic [TBL_KW-1:0] cfg_bp_kind,
  input  logic [PIX_W-1:0]  cfg_dur_sync,
  input  logic [PIX_W-1:0]  cfg_dur_tri,
  input  logic [PIX_W-1:0]  cfg_dur_back,
  input  logic [PIX_W-1:0]  cfg_dur_front,
  input  logic [PIX_W-1:0]  cfg_dur_broad,
  input  logic [LVL_W-1:0]  cfg_lvl_sync,
  input  logic [LVL_W-1:0]  cfg_lvl_tri,
  input  logic [LVL_W-1:0]  cfg_lvl_blank,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              field,
  output logic [KIND_W-1:0] line_type,
  output logic [LVL_W-1:0]  ovr_level,
  output logic              ovr_en
);
  logic load_f1, load_f2, running, frame_upd, split_ok;
  logic [PIX_W-1:0]  s_tot, s_sync, s_tri, s_back, s_front, s_broad;
  logic [LINE_W-1:0] s_field, s_frame;
  logic [TBL_LW-1:0] s_bp_line;
  logic [TBL_KW-1:0] s_bp_kind;
  logic [LVL_W-1:0]  s_lvl_sync, s_lvl_tri, s_lvl_blank;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              field_q;
  line_kind_e        kind;

  assign split_ok = (s_field < s_frame);

  rtg_sync_in u_sync (
    .clk(clk), .rst(rst), .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .split_ok(split_ok), .load_f1(load_f1), .load_f2(load_f2), .running(running)
  );

  rtg_shadow #(.PIX_W(PIX_W), .LINE_W(LINE_W), .LVL_W(LVL_W), .NUM_BP(NUM_BP)) u_shadow (
    .clk(clk), .rst(rst), .upd(frame_upd),
    .in_tot(cfg_total_pix), .in_field(cfg_field_lines), .in_frame(cfg_frame_lines),
    .in_bp_line(cfg_bp_line), .in_bp_kind(cfg_bp_kind),
    .in_sync(cfg_dur_sync), .in_tri(cfg_dur_tri), .in_back(cfg_dur_back),
    .in_front(cfg_dur_front), .in_broad(cfg_dur_broad),
    .in_lvl_sync(cfg_lvl_sync), .in_lvl_tri(cfg_lvl_tri), .in_lvl_blank(cfg_lvl_blank),
    .s_tot(s_tot), .s_field(s_field), .s_frame(s_frame),
    .s_bp_line(s_bp_line), .s_bp_kind(s_bp_kind),
    .s_sync(s_sync), .s_tri(s_tri), .s_back(s_back), .s_front(s_front), .s_broad(s_broad),
    .s_lvl_sync(s_lvl_sync), .s_lvl_tri(s_lvl_tri), .s_lvl_blank(s_lvl_blank)
  );

  rtg_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst(rst), .running(running), .load_f1(load_f1), .load_f2(load_f2),
    .tot(s_tot), .field_sz(s_field), .frame_sz(s_frame),
    .pix_q(pix_q), .line_q(line_q), .field_q(field_q), .frame_upd(frame_upd)
  );

  rtg_line_sel #(.LINE_W(LINE_W), .NUM_BP(NUM_BP)) u_sel (
    .line(line_q), .bp_line(s_bp_line), .bp_kind(s_bp_kind), .kind(kind)
  );

  rtg_shaper #(.PIX_W(PIX_W), .LINE_W(LINE_W), .LVL_W(LVL_W)) u_shape (
    .clk(clk), .rst(rst), .valid(running), .pix(pix_q), .line(line_q), .fld(field_q),
    .kind(kind), .tot(s_tot),
    .d_sync(s_sync), .d_tri(s_tri), .d_back(s_back), .d_front(s_front), .d_broad(s_broad),
    .l_sync(s_lvl_sync), .l_tri(s_lvl_tri), .l_blank(s_lvl_blank),
    .pix_o(pix_cnt), .line_o(line_cnt), .field_o(field), .kind_o(line_type),
    .lvl_o(ovr_level), .en_o(ovr_en)
  );

  // R11: a disabled override never carries an amplitude
  assert_level_zero_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !ovr_en |-> (ovr_level == '0));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int PIX_W = 12, LINE_W = 11, LVL_W = 10, NUM_BP = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, hs_in = 1'b0, vs_in = 1'b0, fid_in = 1'b0;
  logic [PIX_W-1:0]  cfg_total_pix, cfg_dur_sync, cfg_dur_tri, cfg_dur_back, cfg_dur_front, cfg_dur_broad;
  logic [LINE_W-1:0] cfg_field_lines, cfg_frame_lines;
  logic [NUM_BP*LINE_W-1:0] cfg_bp_line;
  logic [NUM_BP*2-1:0]      cfg_bp_kind;
  logic [LVL_W-1:0]  cfg_lvl_sync, cfg_lvl_tri, cfg_lvl_blank;
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              field, ovr_en;
  logic [1:0]        line_type;
  logic [LVL_W-1:0]  ovr_level;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // programmed values and the copy the bench expects to be in force
  int c_tot, c_fs, c_fr, c_sync, c_tri, c_back, c_front, c_broad, c_lsync, c_ltri, c_lblank;
  int c_bp[NUM_BP], c_kind[NUM_BP];
  int a_tot, a_fs, a_fr, a_sync, a_tri, a_back, a_front, a_broad, a_lsync, a_ltri, a_lblank;
  int a_bp[NUM_BP], a_kind[NUM_BP];
  bit m_run = 0;
  int mp = 0, ml = 0;

  assign cfg_total_pix   = PIX_W'(c_tot);
  assign cfg_field_lines = LINE_W'(c_fs);
  assign cfg_frame_lines = LINE_W'(c_fr);
  assign cfg_dur_sync    = PIX_W'(c_sync);
  assign cfg_dur_tri     = PIX_W'(c_tri);
  assign cfg_dur_back    = PIX_W'(c_back);
  assign cfg_dur_front   = PIX_W'(c_front);
  assign cfg_dur_broad   = PIX_W'(c_broad);
  assign cfg_lvl_sync    = LVL_W'(c_lsync);
  assign cfg_lvl_tri     = LVL_W'(c_ltri);
  assign cfg_lvl_blank   = LVL_W'(c_lblank);
  always_comb begin
    for (int i = 0; i < NUM_BP; i++) begin
      cfg_bp_line[i*LINE_W +: LINE_W] = LINE_W'(c_bp[i]);
      cfg_bp_kind[i*2 +: 2]           = 2'(c_kind[i]);
    end
  end

  raster_timing_gen dut (
    .clk(clk), .rst(rst), .hs_in(hs_in), .vs_in(vs_in), .fid_in(fid_in),
    .cfg_total_pix(cfg_total_pix), .cfg_field_lines(cfg_field_lines),
    .cfg_frame_lines(cfg_frame_lines), .cfg_bp_line(cfg_bp_line), .cfg_bp_kind(cfg_bp_kind),
    .cfg_dur_sync(cfg_dur_sync), .cfg_dur_tri(cfg_dur_tri), .cfg_dur_back(cfg_dur_back),
    .cfg_dur_front(cfg_dur_front), .cfg_dur_broad(cfg_dur_broad),
    .cfg_lvl_sync(cfg_lvl_sync), .cfg_lvl_tri(cfg_lvl_tri), .cfg_lvl_blank(cfg_lvl_blank),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field(field), .line_type(line_type),
    .ovr_level(ovr_level), .ovr_en(ovr_en)
  );

  function automatic void chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (line %0d pix %0d)", tag, what, act, exp, ml, mp);
    end
  endfunction

  task automatic adopt();
    a_tot = c_tot; a_fs = c_fs; a_fr = c_fr; a_sync = c_sync; a_tri = c_tri;
    a_back = c_back; a_front = c_front; a_broad = c_broad;
    a_lsync = c_lsync; a_ltri = c_ltri; a_lblank = c_lblank;
    for (int i = 0; i < NUM_BP; i++) begin a_bp[i] = c_bp[i]; a_kind[i] = c_kind[i]; end
  endtask

  function automatic int exp_kind(int line);
    int k = 1;  // R6: fallback when no breakpoint qualifies
    for (int i = 0; i < NUM_BP; i++) if (a_bp[i] <= line) k = a_kind[i];
    return k;
  endfunction

  task automatic exp_wave(input int k, input int p, output int en, output int lvl);
    int h;
    en = 1; lvl = a_lblank; h = a_tot / 2;
    if (k == 0 || k == 1) begin
      if (p < a_sync) lvl = a_lsync;
      else if (p < a_sync + a_tri) lvl = a_ltri;
      else if (p < a_sync + a_tri + a_back) lvl = a_lblank;
      else if (p >= a_tot - a_front) lvl = a_lblank;
      else if (k == 0) begin en = 0; lvl = 0; end
    end else if (k == 2) begin
      if (p < a_broad) lvl = a_lsync;
    end else begin
      if (p < a_sync || (p >= h && p < h + a_sync)) lvl = a_lsync;
    end
  endtask

  task automatic cmp();
    int k, en, lvl;
    string wt;
    if (!m_run) begin
      chk(pix_cnt == 0, "R4", "idle pix", int'(pix_cnt), 0);
      chk(line_cnt == 0, "R4", "idle line", int'(line_cnt), 0);
      chk(ovr_en == 0, "R4", "idle ovr_en", int'(ovr_en), 0);
    end else begin
      chk(int'(pix_cnt) == mp, "R1", "pix", int'(pix_cnt), mp);
      chk(int'(line_cnt) == ml, "R2", "line", int'(line_cnt), ml);
      chk(field == (ml >= a_fs), "R2", "field", int'(field), int'(ml >= a_fs));
      k = exp_kind(ml);
      chk(int'(line_type) == k, "R6", "line_type", int'(line_type), k);
      exp_wave(k, mp, en, lvl);
      wt = (k == 2) ? "R8" : (k == 3) ? "R9" : "R7";
      chk(int'(ovr_en) == en, wt, "ovr_en", int'(ovr_en), en);
      chk(int'(ovr_level) == lvl, wt, "ovr_level", int'(ovr_level), lvl);
    end
    if (!ovr_en) chk(ovr_level == 0, "R11", "level while off", int'(ovr_level), 0);
  endtask

  task automatic adv();
    if (m_run) begin
      if (mp == a_tot - 1) begin
        mp = 0;
        if (ml == a_fr - 1) begin ml = 0; adopt(); end  // R10: frame boundary
        else ml++;
      end else mp++;
    end
  endtask

  task automatic step();
    @(negedge clk); adv(); cmp();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // drive a coincident vertical/horizontal edge; returns after the first cycle
  task automatic sync_pulse(bit fid);
    vs_in = 1'b1; hs_in = 1'b1; fid_in = fid;
    step();
    vs_in = 1'b0; hs_in = 1'b0; fid_in = 1'b0;
  endtask

  task automatic load_expect(int line);
    @(negedge clk);
    if (line == 0) adopt();
    m_run = 1; mp = 0; ml = line;
    cmp();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp();  // R4 reset state
  endtask

  task automatic t_ignore_f2_idle();  // R4
    sync_pulse(1'b1);
    steps(6);
  endtask

  task automatic t_start_and_run();  // R3 R4 R1 R2 R7 R8 R9 R12
    sync_pulse(1'b0);
    load_expect(0);
    steps(a_tot * a_fr * 2 + 25);
  endtask

  task automatic t_vs_before_hs();  // R3: field ID sampled at the vertical edge
    vs_in = 1'b1; fid_in = 1'b1;
    step();
    fid_in = 1'b0;
    steps(3);
    hs_in = 1'b1;
    step();
    hs_in = 1'b0; vs_in = 1'b0;
    load_expect(a_fs);
    steps(a_tot * 3);
  endtask

  task automatic t_realign_f1();  // R3
    steps(7);
    sync_pulse(1'b0);
    load_expect(0);
    steps(a_tot * 2);
  endtask

  task automatic t_cfg_boundary();  // R10
    c_tot = 24; c_sync = 3; c_ltri = 650; c_lblank = 250; c_kind[2] = 0; c_broad = 11;
    steps(a_tot * a_fr * 2 + 24 * 11 + 10);
  endtask

  task automatic t_no_match();  // R6 fallback
    c_bp[0] = 1;
    steps(a_tot * a_fr * 2 + 10);
  endtask

  task automatic t_progressive();  // R5
    c_fs = 6; c_fr = 6;
    steps(a_tot * a_fr + 30);
    sync_pulse(1'b1);
    steps(a_tot * 6 * 2);
  endtask

  initial begin
    c_tot = 20; c_fs = 5; c_fr = 11;
    c_sync = 2; c_tri = 1; c_back = 3; c_front = 2; c_broad = 8;
    c_lsync = 16; c_ltri = 700; c_lblank = 240;
    c_bp[0] = 0;   c_kind[0] = 2;
    c_bp[1] = 2;   c_kind[1] = 1;
    c_bp[2] = 3;   c_kind[2] = 0;
    c_bp[3] = 5;   c_kind[3] = 3;
    c_bp[4] = 6;   c_kind[4] = 1;
    c_bp[5] = 7;   c_kind[5] = 0;
    c_bp[6] = 100; c_kind[6] = 1;
    c_bp[7] = 200; c_kind[7] = 1;
    adopt();
    t_reset();
    t_ignore_f2_idle();
    t_start_and_run();
    t_vs_before_hs();
    t_realign_f1();
    t_cfg_boundary();
    t_no_match();
    t_progressive();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule